// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a set of non-maskable trap requests and a larger set of maskable peripheral interrupt requests into one request line for a processor. Alongside the request it presents the number of the winning vector and the program address of that vector's table entry. The processor reads the service-routine start address from that location.

Each request input is a one-cycle pulse. The pulse sets a pending flag for its source. Every maskable source has an enable bit and a 3-bit user priority. Arbitration runs in two tiers. Any pending trap beats every maskable source, whatever the processor priority. Among maskable sources, a higher user priority wins, and a source only competes when its priority is above the processor's current priority. Within one tier or level, the lower vector number wins.

A single select input chooses between two vector tables with the same layout. The second table lies directly after the first. The registered outputs hold still until the processor acknowledges. The acknowledge clears the pending flag of the source that was presented.

Top module: `pic_vectored_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, the request output is 0, and no source is pending.
- R2: A pending trap wins over every pending maskable source, whatever the enables, the user priorities and the processor priority.
- R3: When several traps are pending, the trap with the lowest index is presented first.
- R4: A maskable source competes only if it is pending, its enable bit is 1 and its 3-bit priority is strictly greater than the processor priority input. A priority of 0 never raises a request.
- R5: Between competing maskable sources, the higher user priority wins, regardless of vector number.
- R6: Between competing maskable sources of equal user priority, the lower vector number wins.
- R7: Vector numbering: trap t is vector t (0 to NUM_TRAPS-1), and maskable source i is vector NUM_TRAPS+i.
- R8: With the table select at 0, the fetch address is 0x000004 + 2*vector.
- R9: With the table select at 1, the fetch address is 0x000004 + 2*(NUM_TRAPS+NUM_IRQS) + 2*vector, which is 0x000100 + 2*vector at the default sizes.
- R10: A request pulse on one clock edge gives an asserted request on the next edge. While the request is high and acknowledge is low, the vector number and the fetch address stay fixed, even if new sources arrive or the priority or select inputs change.
- R11: An acknowledge while the request is high clears only the presented source's pending flag and drops the request for one cycle. The block then re-arbitrates. An acknowledge while the request is low has no effect.
- R12: If a source's request pulse and the acknowledge that clears it fall on the same edge, the source stays pending and is presented again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_pulse | input | NUM_TRAPS | One-cycle trap request pulses; bit t is vector t |
| irq_pulse | input | NUM_IRQS | One-cycle maskable request pulses; bit i is vector NUM_TRAPS+i |
| irq_en | input | NUM_IRQS | Enable bit for each maskable source |
| irq_prio | input | 3*NUM_IRQS | User priority per maskable source; source i uses bits 3i+2..3i |
| cpu_prio | input | 3 | Current processor priority |
| alt_sel | input | 1 | 0 selects the primary table, 1 selects the alternate table |
| ack | input | 1 | Processor acknowledge of the presented vector |
| cpu_req | output | 1 | Interrupt request to the processor |
| vec_num | output | 7 | Number of the presented vector |
| fetch_addr | output | 24 | Program address of the presented vector's table entry |

## Verification
The assertions check the following on every cycle:
- the request and its vector hold still until acknowledge;
- the request falls after an acknowledge;
- a newly raised request names a trap exactly when a trap was pending;
- a maskable winner was enabled and above the processor priority;
- the address is even and lies inside the two tables.

Only the bench's scenarios can show which source actually wins. It does this by sweeping single sources over every priority, trap pairs, trap-against-interrupt pairs and every maskable pair over every priority combination. The same holds for the exact table-base arithmetic, for pending flags that survive an acknowledge while other sources are cleared, and for the same-edge set-and-clear case.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int PRIO_W = 3;
    localparam int LVL_W  = 4;
    localparam int VEC_W  = 7;
    localparam int ADDR_W = 24;

    localparam logic [ADDR_W-1:0] PRIMARY_BASE = 24'h000004;
    localparam logic [LVL_W-1:0]  TRAP_LVL     = 4'd8;

    typedef struct packed {
        logic              valid;
        logic [LVL_W-1:0]  lvl;
        logic [VEC_W-1:0]  idx;
    } win_t;

    // Base of the selected table; the alternate one follows the primary directly.
    function automatic logic [ADDR_W-1:0] table_base(input logic alt, input int slots);
        return alt ? PRIMARY_BASE + ADDR_W'(2 * slots) : PRIMARY_BASE;
    endfunction

    function automatic logic [ADDR_W-1:0] entry_addr(input logic alt,
                                                     input logic [VEC_W-1:0] idx,
                                                     input int slots);
        return table_base(alt, slots) + ADDR_W'({idx, 1'b0});
    endfunction

    // Competing level of a maskable source; zero means it does not compete.
    function automatic logic [LVL_W-1:0] irq_level(input logic pend,
                                                   input logic en,
                                                   input logic [PRIO_W-1:0] prio,
                                                   input logic [PRIO_W-1:0] cpu);
        return (pend && en && (prio > cpu)) ? {1'b0, prio} : '0;
    endfunction
endpackage

// File: rtl/pic_pending.sv
module pic_pending
    import pic_pkg::*;
#(
    parameter int NUM_TRAPS = 8,
    parameter int NUM_IRQS  = 118
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_TRAPS-1:0]          trap_set,
    input  logic [NUM_IRQS-1:0]           irq_set,
    input  logic                          clr_en,
    input  logic [VEC_W-1:0]              clr_idx,
    output logic [NUM_TRAPS+NUM_IRQS-1:0] pend
);
    localparam int SLOTS = NUM_TRAPS + NUM_IRQS;

    logic [SLOTS-1:0] set_all;
    assign set_all = {irq_set, trap_set};

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    pend[g] <= 1'b0;
                else if (set_all[g])
                    pend[g] <= 1'b1;
                else if (clr_en && (clr_idx == VEC_W'(g)))
                    pend[g] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int NUM_TRAPS = 8,
    parameter int NUM_IRQS  = 118
) (
    input  logic [NUM_TRAPS+NUM_IRQS-1:0] pend,
    input  logic [NUM_IRQS-1:0]           irq_en,
    input  logic [NUM_IRQS*PRIO_W-1:0]    irq_prio,
    input  logic [PRIO_W-1:0]             cpu_prio,
    output logic                          win_valid,
    output logic [VEC_W-1:0]              win_idx
);
    localparam int SLOTS = NUM_TRAPS + NUM_IRQS;

    logic [LVL_W-1:0] lvl [SLOTS];
    win_t best;

    generate
        for (genvar t = 0; t < NUM_TRAPS; t++) begin : g_trap
            assign lvl[t] = pend[t] ? TRAP_LVL : '0;
        end
        for (genvar i = 0; i < NUM_IRQS; i++) begin : g_irq
            assign lvl[NUM_TRAPS+i] = irq_level(pend[NUM_TRAPS+i], irq_en[i],
                                                irq_prio[i*PRIO_W +: PRIO_W], cpu_prio);
        end
    endgenerate

    // Scan from the highest index down; ">=" lets the lower index take ties.
    always_comb begin
        best = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if ((lvl[k] != '0) && (lvl[k] >= best.lvl)) begin
                best.valid = 1'b1;
                best.lvl   = lvl[k];
                best.idx   = VEC_W'(k);
            end
        end
    end

    assign win_valid = best.valid;
    assign win_idx   = best.idx;
endmodule

// File: rtl/pic_vector_reg.sv
module pic_vector_reg
    import pic_pkg::*;
#(
    parameter int SLOTS = 126
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_valid,
    input  logic [VEC_W-1:0]  win_idx,
    input  logic              alt_sel,
    input  logic              ack,
    output logic              req,
    output logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] addr,
    output logic              clr_en,
    output logic [VEC_W-1:0]  clr_idx
);
    logic              req_q;
    logic [VEC_W-1:0]  vec_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            vec_q  <= '0;
            addr_q <= PRIMARY_BASE;
        end else if (req_q) begin
            if (ack)
                req_q <= 1'b0;
        end else begin
            req_q  <= win_valid;
            vec_q  <= win_idx;
            addr_q <= entry_addr(alt_sel, win_idx, SLOTS);
        end
    end

    assign clr_en  = ack && req_q;
    assign clr_idx = vec_q;
    assign req     = req_q;
    assign vec     = vec_q;
    assign addr    = addr_q;
endmodule

// File: rtl/pic_vectored_ctrl.sv
module pic_vectored_ctrl
    import pic_pkg::*;
#(
    parameter int NUM_TRAPS = 8,
    parameter int NUM_IRQS  = 118
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_TRAPS-1:0]       trap_pulse,
    input  logic [NUM_IRQS-1:0]        irq_pulse,
    input  logic [NUM_IRQS-1:0]        irq_en,
    input  logic [NUM_IRQS*PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0]          cpu_prio,
    input  logic                       alt_sel,
    input  logic                       ack,
    output logic                       cpu_req,
    output logic [VEC_W-1:0]           vec_num,
    output logic [ADDR_W-1:0]          fetch_addr
);
    localparam int SLOTS = NUM_TRAPS + NUM_IRQS;

    logic [SLOTS-1:0] pend;
    logic             win_valid;
    logic [VEC_W-1:0] win_idx;
    logic             clr_en;
    logic [VEC_W-1:0] clr_idx;

    pic_pending #(.NUM_TRAPS(NUM_TRAPS), .NUM_IRQS(NUM_IRQS)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .trap_set (trap_pulse),
        .irq_set  (irq_pulse),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .pend     (pend)
    );

    pic_arbiter #(.NUM_TRAPS(NUM_TRAPS), .NUM_IRQS(NUM_IRQS)) u_arb (
        .pend      (pend),
        .irq_en    (irq_en),
        .irq_prio  (irq_prio),
        .cpu_prio  (cpu_prio),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    pic_vector_reg #(.SLOTS(SLOTS)) u_vreg (
        .clk       (clk),
        .rst       (rst),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .alt_sel   (alt_sel),
        .ack       (ack),
        .req       (cpu_req),
        .vec       (vec_num),
        .addr      (fetch_addr),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx)
    );
endmodule

// File: rtl/pic_checker.sv
module pic_checker
    import pic_pkg::*;
#(
    parameter int NUM_TRAPS = 8,
    parameter int NUM_IRQS  = 118
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       ack,
    input logic [PRIO_W-1:0]          cpu_prio,
    input logic [NUM_IRQS-1:0]        irq_en,
    input logic [NUM_IRQS*PRIO_W-1:0] irq_prio,
    input logic [NUM_TRAPS-1:0]       trap_pend,
    input logic                       cpu_req,
    input logic [VEC_W-1:0]           vec_num,
    input logic [ADDR_W-1:0]          fetch_addr
);
    localparam int SLOTS = NUM_TRAPS + NUM_IRQS;
    localparam logic [ADDR_W-1:0] ADDR_END = PRIMARY_BASE + ADDR_W'(4 * SLOTS);

    function automatic logic [PRIO_W-1:0] prio_at(input logic [NUM_IRQS*PRIO_W-1:0] f,
                                                  input int k);
        return f[k*PRIO_W +: PRIO_W];
    endfunction

    function automatic logic en_at(input logic [NUM_IRQS-1:0] f, input int k);
        return f[k];
    endfunction

    assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !cpu_req);

    assert_trap_first_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_req) |-> ((int'(vec_num) < NUM_TRAPS) == ($past(trap_pend) != '0)));

    assert_qualified_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(cpu_req) && (int'(vec_num) >= NUM_TRAPS)) |->
        (en_at($past(irq_en), int'(vec_num) - NUM_TRAPS) &&
         (prio_at($past(irq_prio), int'(vec_num) - NUM_TRAPS) > $past(cpu_prio))));

    assert_vec_range_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> (int'(vec_num) < SLOTS));

    assert_addr_window_R9: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> (!fetch_addr[0] && (fetch_addr >= PRIMARY_BASE) && (fetch_addr < ADDR_END)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !ack) |=> (cpu_req && $stable(vec_num) && $stable(fetch_addr)));

    assert_ack_drop_R11: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && ack) |=> !cpu_req);
endmodule

bind pic_vectored_ctrl pic_checker #(.NUM_TRAPS(NUM_TRAPS), .NUM_IRQS(NUM_IRQS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ack        (ack),
    .cpu_prio   (cpu_prio),
    .irq_en     (irq_en),
    .irq_prio   (irq_prio),
    .trap_pend  (pend[NUM_TRAPS-1:0]),
    .cpu_req    (cpu_req),
    .vec_num    (vec_num),
    .fetch_addr (fetch_addr)
);

// File: tb/tb_pic_vectored_ctrl.sv
`timescale 1ns/1ps
module tb_pic_vectored_ctrl;
    localparam int T = 4;
    localparam int N = 8;
    localparam int SLOTS = T + N;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [T-1:0]   trap_pulse = '0;
    logic [N-1:0]   irq_pulse = '0;
    logic [N-1:0]   irq_en = '0;
    logic [N*3-1:0] irq_prio = '0;
    logic [2:0]     cpu_prio = '0;
    logic           alt_sel = 1'b0;
    logic           ack = 1'b0;
    logic           cpu_req;
    logic [6:0]     vec_num;
    logic [23:0]    fetch_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pic_vectored_ctrl #(.NUM_TRAPS(T), .NUM_IRQS(N)) dut (
        .clk(clk), .rst(rst), .trap_pulse(trap_pulse), .irq_pulse(irq_pulse),
        .irq_en(irq_en), .irq_prio(irq_prio), .cpu_prio(cpu_prio), .alt_sel(alt_sel),
        .ack(ack), .cpu_req(cpu_req), .vec_num(vec_num), .fetch_addr(fetch_addr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // Expected address from R8/R9 arithmetic.
    function automatic int exp_addr(input bit alt, input int v);
        return (alt ? 4 + 2 * SLOTS : 4) + 2 * v;
    endfunction

    task automatic observe(input string tag, input bit exp_req, input int v, input bit alt);
        chk({tag, " req"}, int'(cpu_req), int'(exp_req));
        if (exp_req) begin
            chk({tag, " vec R7"}, int'(vec_num), v);
            chk(alt ? {tag, " addr R9"} : {tag, " addr R8"}, int'(fetch_addr), exp_addr(alt, v));
        end
    endtask

    // Pulse at a negedge; return after the edge that registers the outputs.
    task automatic fire(input logic [T-1:0] tm, input logic [N-1:0] im);
        @(negedge clk); trap_pulse = tm; irq_pulse = im;
        @(negedge clk); trap_pulse = '0; irq_pulse = '0;
        @(negedge clk);
    endtask

    // Acknowledge; check the one-cycle drop (R11), return after re-arbitration.
    task automatic do_ack(input string tag);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        chk({tag, " drop R11"}, int'(cpu_req), 0);
        @(negedge clk);
    endtask

    task automatic drain();
        @(negedge clk); irq_en = '1; irq_prio = '1; cpu_prio = 3'd0;
        @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < SLOTS + 2; k++) begin
            if (cpu_req) begin
                ack = 1'b1; @(negedge clk); ack = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("reset R1", int'(cpu_req), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("post-reset R1", int'(cpu_req), 0);
        @(negedge clk);
        chk("idle R1", int'(cpu_req), 0);

        // Single maskable source over every priority and several CPU levels (R4, R7, R8, R9).
        for (int i = 0; i < N; i++) begin
            for (int p = 0; p < 8; p++) begin
                for (int c = 0; c < 8; c += 3) begin
                    bit alt;
                    bit go;
                    alt = 1'((i + p + c) % 2);
                    go = (p > c);
                    @(negedge clk);
                    irq_en = '1; irq_prio = '0; irq_prio[i*3 +: 3] = 3'(p);
                    cpu_prio = 3'(c); alt_sel = alt;
                    fire('0, N'(1) << i);
                    observe("single R4", go, T + i, alt);
                    if (go) begin
                        do_ack("single");
                        chk("single cleared R11", int'(cpu_req), 0);
                    end else begin
                        drain();
                    end
                end
            end
            // Disabled source never requests (R4).
            @(negedge clk);
            irq_en = '1; irq_en[i] = 1'b0; irq_prio = '1; cpu_prio = 3'd0; alt_sel = 1'b0;
            fire('0, N'(1) << i);
            chk("disabled R4", int'(cpu_req), 0);
            drain();
        end

        // Each trap alone, with the CPU at the top level and all interrupts disabled (R2, R7).
        for (int t = 0; t < T; t++) begin
            @(negedge clk); irq_en = '0; cpu_prio = 3'd7; alt_sel = 1'(t % 2);
            fire(T'(1) << t, '0);
            observe("trap R2", 1'b1, t, 1'(t % 2));
            do_ack("trap");
        end

        // Trap pairs: the lower index is presented first (R3).
        for (int a = 0; a < T; a++) begin
            for (int b = a + 1; b < T; b++) begin
                @(negedge clk); alt_sel = 1'b0;
                fire((T'(1) << a) | (T'(1) << b), '0);
                observe("trap pair R3", 1'b1, a, 1'b0);
                do_ack("trap pair");
                observe("trap pair second R3", 1'b1, b, 1'b0);
                do_ack("trap pair 2");
            end
        end

        // Trap against the strongest interrupt (R2).
        for (int t = 0; t < T; t++) begin
            for (int i = 0; i < N; i++) begin
                @(negedge clk); irq_en = '1; irq_prio = '1; cpu_prio = 3'd0; alt_sel = 1'b1;
                fire(T'(1) << t, N'(1) << i);
                observe("trap vs irq R2", 1'b1, t, 1'b1);
                do_ack("trap vs irq");
                observe("irq after trap R11", 1'b1, T + i, 1'b1);
                do_ack("irq after trap");
            end
        end

        // Every maskable pair over every priority pair (R5, R6).
        for (int a = 0; a < N; a++) begin
            for (int b = a + 1; b < N; b++) begin
                for (int pa = 1; pa < 8; pa++) begin
                    for (int pb = 1; pb < 8; pb++) begin
                        int w;
                        int l;
                        w = (pb > pa) ? b : a;
                        l = (w == a) ? b : a;
                        @(negedge clk);
                        irq_en = '1; irq_prio = '0; cpu_prio = 3'd0; alt_sel = 1'b0;
                        irq_prio[a*3 +: 3] = 3'(pa); irq_prio[b*3 +: 3] = 3'(pb);
                        fire('0, (N'(1) << a) | (N'(1) << b));
                        observe((pa == pb) ? "pair tie R6" : "pair level R5", 1'b1, T + w, 1'b0);
                        do_ack("pair");
                        observe("pair loser R11", 1'b1, T + l, 1'b0);
                        do_ack("pair loser");
                    end
                end
            end
        end

        // Hold until acknowledge (R10).
        @(negedge clk);
        irq_en = '1; irq_prio = '0; irq_prio[0 +: 3] = 3'd1; irq_prio[7*3 +: 3] = 3'd7;
        cpu_prio = 3'd0; alt_sel = 1'b0;
        fire('0, N'(1) << 0);
        observe("hold first R10", 1'b1, T, 1'b0);
        @(negedge clk); cpu_prio = 3'd6; alt_sel = 1'b1;
        fire('0, N'(1) << 7);
        observe("hold frozen R10", 1'b1, T, 1'b0);
        @(negedge clk);
        observe("hold still R10", 1'b1, T, 1'b0);
        cpu_prio = 3'd0; alt_sel = 1'b0;
        do_ack("hold");
        observe("hold next R10", 1'b1, T + 7, 1'b0);
        do_ack("hold next");

        // Acknowledge with no request is ignored: the masked flag survives (R11).
        @(negedge clk); irq_prio = '0; irq_prio[3*3 +: 3] = 3'd3; cpu_prio = 3'd7;
        fire('0, N'(1) << 3);
        chk("masked R4", int'(cpu_req), 0);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0; cpu_prio = 3'd0;
        @(negedge clk);
        @(negedge clk);
        observe("idle ack ignored R11", 1'b1, T + 3, 1'b0);
        do_ack("idle ack");

        // Same-edge set and clear keeps the source pending (R12).
        @(negedge clk); irq_prio[2*3 +: 3] = 3'd5;
        fire('0, N'(1) << 2);
        observe("same edge first R12", 1'b1, T + 2, 1'b0);
        @(negedge clk); ack = 1'b1; irq_pulse = N'(1) << 2;
        @(negedge clk); ack = 1'b0; irq_pulse = '0;
        chk("same edge drop R12", int'(cpu_req), 0);
        @(negedge clk);
        observe("same edge again R12", 1'b1, T + 2, 1'b0);
        do_ack("same edge");
        chk("same edge cleared R12", int'(cpu_req), 0);

        done = 1'b1;
        report();
    end
endmodule